// File: doc/BRIEF.md
# Biphasic Transmit Pulse Sequencer

This block sequences one transmit channel of an ultrasound front end. It runs from an 80 MHz clock. It waits for a trigger that has already been coarse-delayed upstream. After the trigger it counts a programmable fine delay. It then plays out a programmable number of biphasic excitation cycles at a programmable frequency. Four control lines steer an external three-level pulser: drive to the positive rail, drive to the negative rail, and two return-to-zero paths, one from each rail.

The delay, the half-period and the burst length are taken from the configuration inputs on the edge that accepts the trigger. After that edge the inputs may change freely. A single-cycle completion strobe marks the end of each burst. Triggers that arrive while a burst is in progress are dropped.

Top module: `biphase_tx_seq`

## Requirements
- R1: Out of reset, and whenever no burst is running, all four control lines and the completion strobe are low.
- R2: The trigger is accepted on a clock edge E while idle. The delay field is 7 bits and counts D clocks, 0..127. Pull-up is then first high in the cycle that follows edge E+D+1, and every line stays low before that.
- R3: One excitation cycle lasts 2H clocks. H is the 6-bit half-period field, valid from 6 to 34. With A = floor(H/2), the cycle runs pull-up for A clocks, one idle clock, return-up for H-A-1 clocks, pull-down for A clocks, one idle clock, and return-down for H-A-1 clocks.
- R4: The burst-length field is 5 bits. A value N from 1 to 31 produces exactly N excitation cycles back to back, with no clocks between them.
- R5: A trigger presented with a burst length of 0 produces no line activity and no completion strobe.
- R6: At most one of the four control lines is high in any cycle. A drive line is always followed by one cycle with every line low.
- R7: The completion strobe is high for exactly one cycle. That cycle immediately follows the final return-down clock.
- R8: A trigger that arrives while a burst or its delay is running has no effect on the output sequence.
- R9: Changes to the configuration inputs after the accepting edge do not alter the burst in progress.
- R10: A trigger sampled at the edge that ends the completion-strobe cycle starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 80 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Coarse-delayed start request |
| half_per_i | input | HALF_W (6) | Half-period in clocks (6..34) |
| fine_dly_i | input | DLY_W (7) | Fine delay in clocks |
| burst_len_i | input | CNT_W (5) | Number of excitation cycles |
| pu_o | output | 1 | Pull to positive rail |
| pd_o | output | 1 | Pull to negative rail |
| rzu_o | output | 1 | Return to zero from positive level |
| rzd_o | output | 1 | Return to zero from negative level |
| done_o | output | 1 | One-cycle end-of-burst strobe |

## Verification
The accepting edge E fixes every deadline. During the D+1 cycles after E every line is low. Excitation cycle p begins at cycle E+D+1+2Hp. The strobe comes at E+D+1+2HN. The driver computes this whole cycle-by-cycle trace on the accepting edge and queues it. The monitor pops one entry at every falling edge, so each output is compared in exactly the cycle in which it is due. When the queue is empty, the monitor expects all outputs to be low. This is how dropped triggers, zero-length bursts and mid-burst configuration changes are checked at the ports.

// File: rtl/biphase_tx_pkg.sv
package biphase_tx_pkg;
  localparam int unsigned DEF_HALF_W = 6;
  localparam int unsigned DEF_DLY_W  = 7;
  localparam int unsigned DEF_CNT_W  = 5;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_PU   = 3'd2,
    PH_GAPU = 3'd3,
    PH_RZU  = 3'd4,
    PH_PD   = 3'd5,
    PH_GAPD = 3'd6,
    PH_RZD  = 3'd7
  } phase_e;
endpackage

// File: rtl/biphase_tx_cfg.sv
module biphase_tx_cfg #(
  parameter int unsigned HALF_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [HALF_W-1:0] drv_m1_o,
  output logic [HALF_W-1:0] rz_m1_o
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] drv_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
    end else if (load_i) begin
      half_q <= half_i;
    end
  end

  // Drive phase takes floor(H/2); return phase takes the rest minus the idle clock.
  always_comb begin
    drv_len  = half_q >> 1;
    drv_m1_o = drv_len - HALF_W'(1);
    rz_m1_o  = half_q - drv_len - HALF_W'(2);
  end
endmodule

// File: rtl/biphase_tx_fsm.sv
module biphase_tx_fsm
  import biphase_tx_pkg::*;
#(
  parameter int unsigned HALF_W = 6,
  parameter int unsigned DLY_W  = 7,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HALF_W-1:0] drv_m1_i,
  input  logic [HALF_W-1:0] rz_m1_i,
  output logic              load_o,
  output phase_e            phase_o,
  output logic              done_o
);
  localparam int unsigned TW = (DLY_W > HALF_W) ? DLY_W : HALF_W;

  phase_e           state_q, state_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             done_q, done_d;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    left_d  = left_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (trig_i && (cnt_i != '0)) begin
          load_o  = 1'b1;
          state_d = PH_WAIT;
          tmr_d   = TW'(dly_i);
          left_d  = cnt_i;
        end
      end
      PH_WAIT: begin
        if (tmr_zero) begin
          state_d = PH_PU;
          tmr_d   = TW'(drv_m1_i);
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      PH_PU: begin
        if (tmr_zero) state_d = PH_GAPU;
        else          tmr_d   = tmr_q - TW'(1);
      end
      PH_GAPU: begin
        state_d = PH_RZU;
        tmr_d   = TW'(rz_m1_i);
      end
      PH_RZU: begin
        if (tmr_zero) begin
          state_d = PH_PD;
          tmr_d   = TW'(drv_m1_i);
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      PH_PD: begin
        if (tmr_zero) state_d = PH_GAPD;
        else          tmr_d   = tmr_q - TW'(1);
      end
      PH_GAPD: begin
        state_d = PH_RZD;
        tmr_d   = TW'(rz_m1_i);
      end
      PH_RZD: begin
        if (tmr_zero) begin
          if (left_q == CNT_W'(1)) begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = PH_PU;
            left_d  = left_q - CNT_W'(1);
            tmr_d   = TW'(drv_m1_i);
          end
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      tmr_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/biphase_tx_drive.sv
module biphase_tx_drive
  import biphase_tx_pkg::*;
(
  input  phase_e phase_i,
  output logic   pu_o,
  output logic   pd_o,
  output logic   rzu_o,
  output logic   rzd_o
);
  always_comb begin
    pu_o  = (phase_i == PH_PU);
    pd_o  = (phase_i == PH_PD);
    rzu_o = (phase_i == PH_RZU);
    rzd_o = (phase_i == PH_RZD);
  end
endmodule

// File: rtl/biphase_tx_seq.sv
module biphase_tx_seq
  import biphase_tx_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  parameter int unsigned DLY_W  = DEF_DLY_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [DLY_W-1:0]  fine_dly_i,
  input  logic [CNT_W-1:0]  burst_len_i,
  output logic              pu_o,
  output logic              pd_o,
  output logic              rzu_o,
  output logic              rzd_o,
  output logic              done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              load;
  logic [HALF_W-1:0] drv_m1;
  logic [HALF_W-1:0] rz_m1;
  phase_e            phase;

  // Reset asserts at once and is released after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  biphase_tx_cfg #(.HALF_W(HALF_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .load_i   (load),
    .half_i   (half_per_i),
    .drv_m1_o (drv_m1),
    .rz_m1_o  (rz_m1)
  );

  biphase_tx_fsm #(.HALF_W(HALF_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .trig_i   (trig_i),
    .dly_i    (fine_dly_i),
    .cnt_i    (burst_len_i),
    .drv_m1_i (drv_m1),
    .rz_m1_i  (rz_m1),
    .load_o   (load),
    .phase_o  (phase),
    .done_o   (done_o)
  );

  biphase_tx_drive u_drive (
    .phase_i (phase),
    .pu_o    (pu_o),
    .pd_o    (pd_o),
    .rzu_o   (rzu_o),
    .rzd_o   (rzd_o)
  );
endmodule

// File: rtl/biphase_tx_seq_chk.sv
module biphase_tx_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pu_o,
  input logic pd_o,
  input logic rzu_o,
  input logic rzd_o,
  input logic done_o
);
  assert_lines_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pu_o, pd_o, rzu_o, rzd_o}));

  assert_gap_after_pu_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pu_o) |-> !(pu_o || pd_o || rzu_o || rzd_o));

  assert_gap_after_pd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> !(pu_o || pd_o || rzu_o || rzd_o));

  assert_rzu_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rzu_o) |-> (!$past(pu_o) && $past(pu_o, 2)));

  assert_rzd_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rzd_o) |-> (!$past(pd_o) && $past(pd_o, 2)));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_rzd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rzd_o));
endmodule

bind biphase_tx_seq biphase_tx_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pu_o   (pu_o),
  .pd_o   (pd_o),
  .rzu_o  (rzu_o),
  .rzd_o  (rzd_o),
  .done_o (done_o)
);

// File: tb/biphase_tx_seq_test.sv
module biphase_tx_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic [5:0] half = 6'd6;
  logic [6:0] dly = 7'd0;
  logic [4:0] cnt = 5'd0;
  logic       pu, pd, rzu, rzd, done;

  int    n_checks = 0;
  int    n_fail = 0;
  logic  mon_en = 1'b0;
  string idle_tag = "R1";
  logic [4:0] qv[$];
  string      qt[$];

  always #4 clk = ~clk;

  biphase_tx_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .half_per_i(half), .fine_dly_i(dly), .burst_len_i(cnt),
    .pu_o(pu), .pd_o(pd), .rzu_o(rzu), .rzd_o(rzd), .done_o(done)
  );

  task automatic push_n(input logic [4:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      qv.push_back(v);
      qt.push_back(tag);
    end
  endtask

  // Expected trace in {pu,pd,rzu,rzd,done} order, starting at the accepting edge.
  task automatic push_burst(input int h, input int d, input int n, input string tag);
    int a;
    a = h / 2;
    push_n(5'b00000, d + 1, {"R2 ", tag});
    for (int p = 0; p < n; p++) begin
      push_n(5'b10000, a, {"R3 R4 ", tag});
      push_n(5'b00000, 1, {"R3 R6 ", tag});
      push_n(5'b00100, h - a - 1, {"R3 ", tag});
      push_n(5'b01000, a, {"R3 R4 ", tag});
      push_n(5'b00000, 1, {"R3 R6 ", tag});
      push_n(5'b00010, h - a - 1, {"R3 ", tag});
    end
    push_n(5'b00001, 1, {"R7 ", tag});
  endtask

  task automatic fire(input int h, input int d, input int n, input string tag);
    half = 6'(h);
    dly  = 7'(d);
    cnt  = 5'(n);
    trig = 1'b1;
    @(posedge clk);
    #1 trig = 1'b0;
    push_burst(h, d, n, tag);
  endtask

  task automatic poke();
    @(negedge clk);
    trig = 1'b1;
    @(posedge clk);
    #1 trig = 1'b0;
  endtask

  task automatic drain();
    wait (qv.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [4:0] obs, exp;
      string tag;
      obs = {pu, pd, rzu, rzd, done};
      if (qv.size() != 0) begin
        exp = qv.pop_front();
        tag = qt.pop_front();
      end else begin
        exp = 5'b00000;
        tag = idle_tag;
      end
      n_checks++;
      if (obs !== exp) begin
        n_fail++;
        $display("FAIL %s at %0t: outputs %b expected %b", tag, $time, obs, exp);
      end
      n_checks++;
      if ($countones(obs[4:1]) > 1) begin
        n_fail++;
        $display("FAIL R6 at %0t: lines %b expected at most one high", $time, obs[4:1]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    repeat (10) @(negedge clk);            // R1 idle after reset

    fire(6, 0, 1, "R2 min");                // shortest half-period, zero delay
    drain();
    fire(34, 127, 2, "R2 max");             // longest half-period, longest delay
    drain();
    fire(7, 5, 3, "R4 odd");                // odd half-period split
    drain();
    fire(6, 3, 31, "R4 long");              // full-length burst
    drain();

    idle_tag = "R5";                        // zero-length burst must stay silent
    half = 6'd8; dly = 7'd2; cnt = 5'd0;
    poke();
    repeat (60) @(negedge clk);
    idle_tag = "R1";

    fire(10, 4, 2, "R8");                   // retriggers mid-delay and mid-burst
    poke();
    repeat (15) @(negedge clk);
    poke();
    drain();

    fire(12, 2, 2, "R9");                   // inputs scrambled right after accept
    half = 6'd6; dly = 7'd0; cnt = 5'd31;
    drain();

    fire(8, 1, 1, "R10 first");
    wait (qv.size() == 0);                  // done cycle just checked
    fire(9, 0, 2, "R10 second");
    drain();

    finish_run();
  end
endmodule